// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Claim and Complete

This block is the decision stage that a platform interrupt controller places in front of one interrupt target. It receives the pending state of every source, a two-bit priority for each source, the target's own enable mask and the target's priority threshold. From these it picks the single best source and raises the target's interrupt line whenever any source qualifies.

A source qualifies when it is pending, enabled for this target, not already claimed, and its priority is strictly greater than the threshold. Source number 0 is reserved as the "nothing" code and never qualifies. Among qualifying sources the highest priority wins, and on a tie the lower number wins.

The target takes an interrupt by pulsing the claim input. The block answers with the winner's number, or 0 if nothing qualified, and marks that source as claimed so a second claim cannot return it. Handing the number back on the complete input releases the source. Any number of claims may be open at once, and they may be completed in any order.

Top module: `irq_arb_top`

## Requirements
- R1: After reset the interrupt line is low, the claim result is 0 and no source is in the claimed state.
- R2: A source qualifies only when its priority is strictly greater than the threshold. A priority-0 source never qualifies at any threshold.
- R3: A source whose bit in the target enable mask is 0 never qualifies, even if it is pending and has a high priority.
- R4: Among the qualifying sources, the one with the numerically largest priority is selected. When several share that priority, the smallest source number is selected.
- R5: Source number 0 never qualifies. Its pending, enable and priority inputs have no effect on the interrupt line or on the claim result.
- R6: The interrupt line is registered. It goes high on the first clock edge at which at least one source qualifies, and goes low on the first clock edge at which none does.
- R7: A claim pulse sampled at a clock edge loads the number of the source selected at that edge into the claim result. The result is 0 when no source qualifies. It holds its value until the next claim.
- R8: A claimed source is excluded from selection, and from driving the interrupt line, until the same number is presented on the complete input.
- R9: Several claims may be open at the same time. Completing them in an order other than the reverse of the claim order releases exactly the completed source.
- R10: A complete that carries 0, or carries the number of a source that is not currently claimed, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pending_i | input | NUM_SRC | Pending flag for each source, bit n for source n |
| src_prio_i | input | NUM_SRC*2 | Priority of source n in bits [2n+1:2n] |
| tgt_enable_i | input | NUM_SRC | Target enable mask, bit n for source n |
| tgt_thresh_i | input | 2 | Target priority threshold |
| claim_req_i | input | 1 | One-cycle claim pulse |
| claim_id_o | output | ID_W | Source number returned by the last claim, 0 for none |
| cmpl_valid_i | input | 1 | One-cycle complete pulse |
| cmpl_id_i | input | ID_W | Source number being completed |
| irq_o | output | 1 | Target interrupt line |

## Verification
The interrupt line follows a change in pending, enable, priority or threshold after exactly one clock edge. It follows a claim or complete only after a second edge, because the claimed state must update first. A claim result is valid right after the edge that samples the claim pulse.

The bench drives every input on the falling edge and samples on the falling edge that comes after the required number of rising edges. One directed check also confirms that the line has not yet changed before the first edge. The sweep covers every pending pattern, every threshold, and several priority and enable patterns. After each vector the bench claims the winner and then completes it, so that every vector starts from an empty claimed state.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_NONE = '0;

    // strict comparison: equal priority never clears the threshold
    function automatic logic prio_clears(prio_t prio, prio_t thresh);
        return prio > thresh;
    endfunction

    function automatic int id_width(int num_src);
        return (num_src > 1) ? $clog2(num_src) : 1;
    endfunction

endpackage

// File: rtl/irq_arb_eligible.sv
module irq_arb_eligible
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] enable_i,
    input  logic [NUM_SRC-1:0] claimed_i,
    input  prio_t              prio_i [NUM_SRC],
    input  prio_t              thresh_i,
    output logic [NUM_SRC-1:0] elig_o,
    output logic               any_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g == 0) begin : g_reserved
            logic unused_src0;
            assign unused_src0 = pend_i[0] ^ enable_i[0] ^ claimed_i[0] ^ (^prio_i[0]);
            assign elig_o[0]   = 1'b0;
        end else begin : g_real
            assign elig_o[g] = pend_i[g] & enable_i[g] & ~claimed_i[g]
                             & prio_clears(prio_i[g], thresh_i);
        end
    end

    assign any_o = |elig_o;

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SRC-1:0] elig_i,
    input  prio_t              prio_i [NUM_SRC],
    output logic [ID_W-1:0]    best_id_o,
    output prio_t              best_prio_o
);

    // ascending scan with a strict compare keeps the lowest number on ties
    always_comb begin
        best_id_o   = '0;
        best_prio_o = PRIO_NONE;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (elig_i[i] && (prio_i[i] > best_prio_o)) begin
                best_id_o   = ID_W'(i);
                best_prio_o = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_arb_claims.sv
module irq_arb_claims #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               claim_i,
    input  logic [ID_W-1:0]    claim_id_i,
    input  logic               cmpl_i,
    input  logic [ID_W-1:0]    cmpl_id_i,
    output logic [NUM_SRC-1:0] claimed_o
);

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] claimed_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (g == 0) begin : g_zero
            assign set_vec[0] = 1'b0;
            assign clr_vec[0] = 1'b0;
        end else begin : g_live
            assign set_vec[g] = claim_i && (claim_id_i == ID_W'(g));
            // an unclaimed number clears a bit that is already 0
            assign clr_vec[g] = cmpl_i && (cmpl_id_i == ID_W'(g));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            claimed_q <= '0;
        end else begin
            claimed_q <= (claimed_q & ~clr_vec) | set_vec;
        end
    end

    assign claimed_o = claimed_q;

    p_claim_marks_r8: assert property (@(posedge clk) disable iff (rst)
        (claim_i && claim_id_i != '0) |=> claimed_q[$past(claim_id_i)]);

    p_cmpl_zero_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && cmpl_id_i == '0 && !claim_i) |=> $stable(claimed_q));

    p_cmpl_unclaimed_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && cmpl_id_i != '0 && !claimed_q[cmpl_id_i] && !claim_i)
            |=> $stable(claimed_q));

    p_src0_never_claimed_r5: assert property (@(posedge clk) disable iff (rst)
        !claimed_q[0]);

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int ID_W   = id_width(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        src_pending_i,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
    input  logic [NUM_SRC-1:0]        tgt_enable_i,
    input  logic [PRIO_W-1:0]         tgt_thresh_i,
    input  logic                      claim_req_i,
    output logic [ID_W-1:0]           claim_id_o,
    input  logic                      cmpl_valid_i,
    input  logic [ID_W-1:0]           cmpl_id_i,
    output logic                      irq_o
);

    prio_t              prio_arr [NUM_SRC];
    logic [NUM_SRC-1:0] claimed;
    logic [NUM_SRC-1:0] elig;
    logic               any_elig;
    logic [ID_W-1:0]    best_id;
    prio_t              best_prio;
    logic [ID_W-1:0]    claim_id_q;
    logic               irq_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign prio_arr[g] = src_prio_i[g*PRIO_W +: PRIO_W];
    end

    irq_arb_eligible #(.NUM_SRC(NUM_SRC)) u_elig (
        .pend_i    (src_pending_i),
        .enable_i  (tgt_enable_i),
        .claimed_i (claimed),
        .prio_i    (prio_arr),
        .thresh_i  (tgt_thresh_i),
        .elig_o    (elig),
        .any_o     (any_elig)
    );

    irq_arb_select #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_sel (
        .elig_i      (elig),
        .prio_i      (prio_arr),
        .best_id_o   (best_id),
        .best_prio_o (best_prio)
    );

    irq_arb_claims #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_claims (
        .clk        (clk),
        .rst        (rst),
        .claim_i    (claim_req_i),
        .claim_id_i (best_id),
        .cmpl_i     (cmpl_valid_i),
        .cmpl_id_i  (cmpl_id_i),
        .claimed_o  (claimed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            claim_id_q <= '0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= any_elig;
            if (claim_req_i) begin
                claim_id_q <= best_id;
            end
        end
    end

    assign claim_id_o = claim_id_q;
    assign irq_o      = irq_q;

    p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
        any_elig |=> irq_o);

    p_irq_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !any_elig |=> !irq_o);

    p_empty_claim_r7: assert property (@(posedge clk) disable iff (rst)
        (claim_req_i && !any_elig) |=> claim_id_o == '0);

    p_winner_eligible_r4: assert property (@(posedge clk) disable iff (rst)
        (best_id != '0) |-> elig[best_id]);

    p_winner_above_thresh_r2: assert property (@(posedge clk) disable iff (rst)
        (best_id != '0) |-> best_prio > tgt_thresh_i);

    p_found_when_any_r4: assert property (@(posedge clk) disable iff (rst)
        any_elig |-> best_id != '0);

endmodule

// File: tb/irq_arb_top_test.sv
module irq_arb_top_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pend = '0;
    logic [2*N-1:0] prio = '0;
    logic [N-1:0] en = '0;
    logic [1:0]   thr = '0;
    logic         claim_req = 1'b0;
    logic [2:0]   claim_id;
    logic         cmpl_valid = 1'b0;
    logic [2:0]   cmpl_id = '0;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    irq_arb_top #(.NUM_SRC(N)) uut (
        .clk           (clk),
        .rst           (rst),
        .src_pending_i (pend),
        .src_prio_i    (prio),
        .tgt_enable_i  (en),
        .tgt_thresh_i  (thr),
        .claim_req_i   (claim_req),
        .claim_id_o    (claim_id),
        .cmpl_valid_i  (cmpl_valid),
        .cmpl_id_i     (cmpl_id),
        .irq_o         (irq)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model_best(logic [N-1:0] p, logic [N-1:0] e,
                                      logic [N-1:0] c, logic [2*N-1:0] pr, int t);
        int best = 0;
        int bp = 0;
        for (int i = 1; i < N; i++) begin
            int v = int'(pr[2*i +: 2]);
            if (p[i] && e[i] && !c[i] && v > t && v > bp) begin
                bp = v;
                best = i;
            end
        end
        return best;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_claim(output int id);
        claim_req = 1'b1;
        step();
        claim_req = 1'b0;
        id = int'(claim_id);
    endtask

    task automatic do_cmpl(input int id);
        cmpl_valid = 1'b1;
        cmpl_id = 3'(id);
        step();
        cmpl_valid = 1'b0;
        cmpl_id = '0;
    endtask

    function automatic logic [2*N-1:0] set_prio(input logic [2*N-1:0] base, input int i, input int v);
        logic [2*N-1:0] r = base;
        r[2*i +: 2] = 2'(v);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int got;
        logic [7:0] en_pat [4];
        en_pat[0] = 8'hFF; en_pat[1] = 8'h7E; en_pat[2] = 8'hAD; en_pat[3] = 8'hF3;

        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        check("R1 irq after reset", int'(irq), 0);
        check("R1 claim id after reset", int'(claim_id), 0);
        do_claim(got);
        check("R1 nothing claimed or pending", got, 0);

        // R5: source 0 fully active must have no effect
        pend = 8'h01; en = 8'hFF; thr = 2'd0; prio = set_prio('0, 0, 3);
        step();
        check("R5 src0 irq", int'(irq), 0);
        do_claim(got);
        check("R5 src0 claim", got, 0);

        // R2: priority 0 never qualifies
        pend = 8'h08; prio = '0;
        step();
        check("R2 prio0 irq", int'(irq), 0);

        // R2: equal priority to threshold does not qualify
        prio = set_prio('0, 3, 2); thr = 2'd2;
        step();
        check("R2 prio equal thresh", int'(irq), 0);

        // R6: registered, no change before the edge, change after one edge
        thr = 2'd1;
        #1;
        check("R6 before edge", int'(irq), 0);
        @(negedge clk);
        check("R6 after one edge", int'(irq), 1);

        // R3: enable mask blocks
        en = 8'hF7;
        step();
        check("R3 disabled source irq", int'(irq), 0);
        do_claim(got);
        check("R3 disabled source claim", got, 0);

        // R4 tie: sources 2 and 5 prio 2, source 6 prio 1, source 1 prio 3 disabled
        en = 8'hFD; thr = 2'd0; pend = 8'h66;
        prio = set_prio(set_prio(set_prio(set_prio('0, 2, 2), 5, 2), 6, 1), 1, 3);
        pend[1] = 1'b1;
        step();
        do_claim(got);
        check("R4 tie lowest id", got, 2);
        // R9: several open claims
        do_claim(got);
        check("R8 claimed excluded", got, 5);
        do_claim(got);
        check("R9 third open claim", got, 6);
        do_claim(got);
        check("R9 all claimed empty", got, 0);
        step();
        check("R8 irq low while all claimed", int'(irq), 0);
        // R10: ignored completes
        do_cmpl(0);
        do_cmpl(7);
        step();
        check("R10 irq unchanged", int'(irq), 0);
        do_claim(got);
        check("R10 claim still empty", got, 0);
        // R9: out of order completion of the middle claim
        do_cmpl(5);
        step();
        check("R9 irq after out of order complete", int'(irq), 1);
        do_claim(got);
        check("R9 reclaim released source", got, 5);
        do_cmpl(6);
        do_cmpl(2);
        do_claim(got);
        check("R8 completed source returns", got, 2);
        do_cmpl(2);
        do_cmpl(5);
        step();

        // sweep: thresholds x pending patterns x priority/enable patterns
        for (int k = 0; k < 4; k++) begin
            logic [2*N-1:0] pp = '0;
            for (int i = 0; i < N; i++) pp = set_prio(pp, i, (i*(k+1)+k) % 4);
            for (int t = 0; t < 4; t++) begin
                for (int pv = 0; pv < 256; pv++) begin
                    int exp;
                    pend = 8'(pv); prio = pp; en = en_pat[k]; thr = 2'(t);
                    exp = model_best(8'(pv), en_pat[k], '0, pp, t);
                    step();
                    check("R2 R3 R6 sweep irq", int'(irq), (exp != 0) ? 1 : 0);
                    do_claim(got);
                    check("R4 R7 sweep claim", got, exp);
                    if (got != 0) do_cmpl(got);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule